// File: doc/BRIEF.md
# Software-Raisable Interrupt Status Controller

This block holds a 32-bit word of pending interrupt causes and drives one level-sensitive interrupt line toward the host. Software can post any cause bits itself by writing a mask to a raise address. It retires causes by writing a mask to a separate acknowledge address. Reads never clear anything. Two internal engines, a compute unit and a DMA unit, report completion through single-cycle pulses. Each pulse ORs a fixed cause bit into the same word.

The line follows the status word through one register stage. It stays high for as long as any cause remains pending, so an interrupt handler must acknowledge every bit it has seen. Reads go through a simple strobe interface and return data one cycle later with a valid flag.

Top module: `sw_irq_status_ctrl`

## Requirements
- R1: After synchronous reset, the status word is zero, `irq_o` is low, `rd_data` is zero and `rd_valid` is low.
- R2: A write to offset 0x60 ORs `wr_data` into the status word at the next clock edge. Bits that were already set stay set.
- R3: A write to offset 0x64 clears, at the next clock edge, every status bit that is 1 in `wr_data`. Bits that are 0 in the mask are untouched.
- R4: If an acknowledge write and an internal source pulse hit the same bit in one cycle, the bit ends up set.
- R5: A pulse on `calc_done` sets status bit 0 (value 0x001).
- R6: A pulse on `dma_done` sets status bit 8 (value 0x100).
- R7: `irq_o` is high in the cycle after the status word is non-zero. It is low in the cycle after the status word is zero. This gives one cycle of lag in both directions.
- R8: A read strobe at offset 0x24 returns the status word as it stood before that edge, on `rd_data` one cycle later with `rd_valid` high. Reads at 0x60 or 0x64 return zero.
- R9: A write to offset 0x24, or to any offset other than 0x60 or 0x64, leaves the status word unchanged.
- R10: A software raise, a `calc_done` pulse and a `dma_done` pulse in the same cycle all set their bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte offset of the access |
| wr_data | input | 32 | Write data, used as a raise or acknowledge mask |
| calc_done | input | 1 | Compute-engine completion pulse |
| dma_done | input | 1 | DMA-engine completion pulse |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rd_data` answers a read |
| irq_o | output | 1 | Level interrupt line, high while any cause is pending |

## Verification
The interesting collisions are an acknowledge write landing in the same cycle as an engine completion pulse, and a software raise coinciding with both engine pulses. The bench drives each such cycle directly: the write strobe and the pulses go high on the same falling edge. It then reads the status word back through the read port. The acknowledged bits that a pulse also touched must survive. Every raised source must be present in the word, as predicted by a reference model that applies clear-then-set for each cycle.

// File: rtl/irq_ctrl_pkg.sv
// Package: irq_ctrl_pkg
// Shared offsets, cause-bit positions and the decoded strobe bundle for the
// interrupt status controller. Offsets are byte addresses seen by software.
package irq_ctrl_pkg;

    localparam int unsigned OFS_STATUS = 32'h24;
    localparam int unsigned OFS_RAISE  = 32'h60;
    localparam int unsigned OFS_ACK    = 32'h64;

    localparam int unsigned CALC_CAUSE_BIT = 0;
    localparam int unsigned DMA_CAUSE_BIT  = 8;

    // One-hot-ish strobes produced by the address decoder.
    typedef struct packed {
        logic do_raise;
        logic do_ack;
        logic rd_status;
        logic rd_any;
    } irq_strobe_t;

endpackage

// File: rtl/irq_addr_decode.sv
// Module: irq_addr_decode
// Turns a bus strobe plus byte offset into the action strobes the
// controller needs. Assumes at most one of wr_en / rd_en per cycle matters;
// a write and a read in the same cycle are decoded independently.
module irq_addr_decode
    import irq_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output irq_strobe_t       strb
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_RAISE  = ADDR_W'(OFS_RAISE);
    localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);

    // Compare the offset against each known location.
    always_comb begin
        strb.do_raise  = wr_en && (addr == A_RAISE);
        strb.do_ack    = wr_en && (addr == A_ACK);
        strb.rd_status = rd_en && (addr == A_STATUS);
        strb.rd_any    = rd_en;
    end

endmodule

// File: rtl/irq_cause_accum.sv
// Module: irq_cause_accum
// Holds the pending-cause word. Each cycle every bit is first cleared by the
// acknowledge mask and then set by the raise mask or an engine pulse, so a
// set always wins over a clear on the same bit.
// Assumes the engine pulses are synchronous to clk and one cycle wide.
module irq_cause_accum #(
    parameter int DATA_W   = 32,
    parameter int CALC_BIT = 0,
    parameter int DMA_BIT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_raise,
    input  logic              do_ack,
    input  logic [DATA_W-1:0] mask,
    input  logic              calc_done,
    input  logic              dma_done,
    output logic [DATA_W-1:0] status
);

    logic [DATA_W-1:0] src_vec;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    // Place each engine pulse on its own cause bit.
    always_comb begin
        src_vec           = '0;
        src_vec[CALC_BIT] = calc_done;
        src_vec[DMA_BIT]  = src_vec[DMA_BIT] | dma_done;
    end

    // Merge software and engine requests into set and clear vectors.
    always_comb begin
        set_vec = (do_raise ? mask : '0) | src_vec;
        clr_vec = do_ack ? mask : '0;
    end

    // One flop per cause bit, clear first then set.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else begin
                status[i] <= set_vec[i] | (status[i] & ~clr_vec[i]);
            end
        end
    end

endmodule

// File: rtl/irq_line_drive.sv
// Module: irq_line_drive
// Drives the level interrupt line as a registered OR of the pending word.
// Assumes the consumer is level-sensitive and tolerates one cycle of lag.
module irq_line_drive #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status,
    output logic              irq
);

    // Register the any-pending condition so the line is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |status;
        end
    end

endmodule

// File: rtl/irq_read_port.sv
// Module: irq_read_port
// Registered read return. Status reads see the word before the current
// edge; the write-only locations and unknown offsets read as zero.
module irq_read_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_any,
    input  logic              rd_status,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Capture the selected value and flag it valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_any;
            if (rd_any) begin
                rd_data <= rd_status ? status : '0;
            end
        end
    end

endmodule

// File: rtl/sw_irq_status_ctrl.sv
// Module: sw_irq_status_ctrl
// Top of the interrupt status controller: decoder, cause accumulator,
// interrupt line register and read port. Assumes a simple strobe bus with
// full-word accesses only.
module sw_irq_status_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              calc_done,
    input  logic              dma_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq_o
);

    irq_strobe_t       strb;
    logic [DATA_W-1:0] status_q;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .strb  (strb)
    );

    irq_cause_accum #(
        .DATA_W   (DATA_W),
        .CALC_BIT (CALC_CAUSE_BIT),
        .DMA_BIT  (DMA_CAUSE_BIT)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_raise  (strb.do_raise),
        .do_ack    (strb.do_ack),
        .mask      (wr_data),
        .calc_done (calc_done),
        .dma_done  (dma_done),
        .status    (status_q)
    );

    irq_line_drive #(.DATA_W(DATA_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .irq    (irq_o)
    );

    irq_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_any    (strb.rd_any),
        .rd_status (strb.rd_status),
        .status    (status_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/irq_status_chk.sv
// Module: irq_status_chk
// Property checker for sw_irq_status_ctrl, attached by bind below.
module irq_status_chk
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              calc_done,
    input logic              dma_done,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

    p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RAISE) |=> ((status & $past(wr_data)) == $past(wr_data)));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ACK && !calc_done && !dma_done) |=> ((status & $past(wr_data)) == '0));

    p_set_beats_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ACK && dma_done) |=> status[DMA_CAUSE_BIT]);

    p_calc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |=> status[CALC_CAUSE_BIT]);

    p_dma_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> status[DMA_CAUSE_BIT]);

    p_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> irq_o);

    p_line_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq_o);

    p_wo_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_RAISE || addr == A_ACK)) |=> (rd_valid && rd_data == '0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && (addr == A_RAISE || addr == A_ACK)) && !calc_done && !dma_done) |=> $stable(status));

endmodule

bind sw_irq_status_ctrl irq_status_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .calc_done (calc_done),
    .dma_done  (dma_done),
    .status    (status_q),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .irq_o     (irq_o)
);

// File: tb/sw_irq_status_ctrl_bench.sv
// Scoreboard bench: driver tasks push expected read data into a queue and a
// monitor pops and compares whenever the design returns a read.
module sw_irq_status_ctrl_bench;

    localparam logic [7:0] A_STATUS = 8'h24;
    localparam logic [7:0] A_RAISE  = 8'h60;
    localparam logic [7:0] A_ACK    = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic        calc_done = 1'b0;
    logic        dma_done = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        irq_o;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] model = '0;
    logic [31:0] q_data[$];
    string       q_tag[$];
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    sw_irq_status_ctrl u_sw_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .calc_done(calc_done), .dma_done(dma_done),
        .rd_data(rd_data), .rd_valid(rd_valid), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per returned read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_data.size() == 0) begin
                check("R8 unexpected read return", 32'h1, 32'h0);
            end else begin
                check(q_tag.pop_front(), rd_data, q_data.pop_front());
            end
        end
    end

    // Driver: one bus cycle with optional engine pulses; updates the model.
    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic c, input logic m);
        logic [31:0] set_v;
        logic [31:0] clr_v;
        wr_en = w; addr = a; wr_data = d; calc_done = c; dma_done = m;
        @(negedge clk);
        wr_en = 1'b0; calc_done = 1'b0; dma_done = 1'b0;
        set_v = (w && a == A_RAISE) ? d : '0;
        clr_v = (w && a == A_ACK) ? d : '0;
        if (c) set_v[0] = 1'b1;
        if (m) set_v[8] = 1'b1;
        model = (model & ~clr_v) | set_v;
    endtask

    // Driver: read one offset and queue its expected return value.
    task automatic rd(input logic [7:0] a, input string tag);
        rd_en = 1'b1; addr = a;
        q_data.push_back((a == A_STATUS) ? model : 32'h0);
        q_tag.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain;
        while (q_data.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        check("R1 rd_valid after reset", {31'b0, rd_valid}, 32'h0);
        check("R1 rd_data after reset", rd_data, 32'h0);
        rd(A_STATUS, "R1 status after reset");
        drain();

        cyc(1'b1, A_RAISE, 32'h0000_0005, 1'b0, 1'b0);
        check("R7 irq lags raise", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R7 irq high after raise", {31'b0, irq_o}, 32'h1);
        rd(A_STATUS, "R2 raise 0x5");
        cyc(1'b1, A_RAISE, 32'h8000_0000, 1'b0, 1'b0);
        rd(A_STATUS, "R2 raise ORs in");
        cyc(1'b1, A_ACK, 32'h0000_0004, 1'b0, 1'b0);
        rd(A_STATUS, "R3 ack clears only masked");
        cyc(1'b1, A_ACK, 32'h0000_0F00, 1'b0, 1'b0);
        rd(A_STATUS, "R3 ack of clear bits no effect");
        rd(A_RAISE, "R8 raise offset reads zero");
        rd(A_ACK, "R8 ack offset reads zero");
        cyc(1'b1, A_STATUS, 32'hFFFF_FFFF, 1'b0, 1'b0);
        rd(A_STATUS, "R9 write to status ignored");
        cyc(1'b1, 8'h30, 32'h0000_FFF0, 1'b0, 1'b0);
        rd(A_STATUS, "R9 write to unused offset ignored");
        drain();

        cyc(1'b1, A_ACK, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R7 irq still high one cycle after clear", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R7 irq low after clear", {31'b0, irq_o}, 32'h0);
        rd(A_STATUS, "R3 full ack");

        cyc(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
        rd(A_STATUS, "R5 calc cause bit 0");
        cyc(1'b1, A_ACK, 32'h1, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
        rd(A_STATUS, "R6 dma cause bit 8");
        cyc(1'b1, A_ACK, 32'hFFFF_FFFF, 1'b0, 1'b0);

        cyc(1'b1, A_RAISE, 32'h0000_0010, 1'b1, 1'b1);
        rd(A_STATUS, "R10 raise plus both pulses");
        cyc(1'b1, A_ACK, 32'h0000_0111, 1'b1, 1'b1);
        rd(A_STATUS, "R4 pulse beats ack");
        check("R4 model keeps pulsed bits", model, 32'h0000_0101);
        cyc(1'b1, A_ACK, 32'h0000_0101, 1'b0, 1'b1);
        rd(A_STATUS, "R4 dma pulse beats ack");
        drain();
        finish_run();
    end

endmodule